// File: doc/BRIEF.md
# Contiguous-Mapping Page Table Entry Evaluator

This block judges a single 64-bit page table entry that a hardware page walker has just read. The walker supplies the entry together with the virtual address under translation, the walk level the entry came from (level 0 is the root and level 2 maps 4 KiB pages), the number of virtual page bits that a superpage at that level passes straight through, and a switch that allows naturally aligned power-of-two contiguous mappings. The block answers with one of three outcomes: fault, descend to the next table, or leaf. For a next-table outcome it gives the base address of that table. For a leaf it gives the translated physical address, which includes the merge for 64 KiB contiguous regions.

The top bit of an entry marks a contiguous region. The block clears that bit before it takes the physical page number from the entry. It finds the size of the region from the trailing zeros of the page number and replaces the low page-number bits with virtual page bits. A request is taken on a valid/ready handshake and the answer appears in one output register. The answer stays there until the walker accepts it.

Top module: `pte_eval`

## Requirements
- R1: If the contiguous switch is off and entry bit 63 is set, the outcome is fault (code 2). This check comes before every other check, including the valid check.
- R2: An entry whose valid bit (bit 0) is clear gives fault (code 2).
- R3: A valid entry with read, write and execute (bits 1, 2, 3) all clear, and with none of user (bit 4), accessed (bit 6), dirty (bit 7) or bit 63 set, gives next level (code 1). The next table base is the page number (entry bits 62:10) shifted left by 12 and cut to 56 bits.
- R4: A pointer entry (bits 3:1 all zero) with any of bit 4, bit 6, bit 7 or bit 63 set gives fault.
- R5: A leaf with bit 63 set faults when its page number is zero or when its level is not 2.
- R6: A leaf with bit 63 set has a region of 2^k pages, where k is the number of trailing zeros of the page number plus one. Only k = 4 is accepted, which means page number bits 3:0 equal 4'b1000. Any other k gives fault.
- R7: For an accepted contiguous leaf (code 0), the low 4 bits of the physical page number come from the virtual page number (VA bits 15:12). The other page-number bits come from the entry, ORed with any superpage pass-through bits.
- R8: For a leaf without bit 63, the physical address is ((PPN OR (VPN AND (2^shift − 1))) << 12) OR VA[11:0], cut to 56 bits. The VPN is VA[38:12].
- R9: The physical address output is zero unless the code is 0. The next-base output is zero unless the code is 1.
- R10: A request is accepted when req_valid and req_ready are both high, where req_ready = !rsp_valid || rsp_ready. Its response is valid on the next cycle and holds steady while rsp_ready is low.
- R11: During reset and on the first cycle after it, rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_pte | input | 64 | Entry to evaluate |
| req_va | input | 39 | Virtual address being translated |
| req_level | input | 2 | Walk level of the entry, 2 = 4 KiB level |
| req_sp_shift | input | 5 | Virtual page bits passed through by a superpage |
| napot_en | input | 1 | Allows contiguous-region entries |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Walker takes the response |
| rsp_code | output | 2 | 0 leaf, 1 next level, 2 fault |
| rsp_pa | output | 56 | Translated physical address |
| rsp_next_base | output | 56 | Base of the next table |

## Verification
Each outcome is due exactly one clock edge after the edge that accepts its request, and it stays unchanged for as long as rsp_ready is held low. The bench keeps a reference that mirrors this timing. The reference captures its expected outcome at the same accepting edge the design uses. At every falling edge the bench compares all outputs and req_ready with that reference, so a response that is early, late or lost under backpressure shows up as a mismatch. Each stored expectation carries the requirement tag of the request that produced it, and a failure is reported against that requirement.

// File: rtl/pte_eval_pkg.sv
package pte_eval_pkg;

    parameter int PTE_W    = 64;
    parameter int VA_W     = 39;
    parameter int PA_W     = 56;
    parameter int PG_SHIFT = 12;
    parameter int PPN_LSB  = 10;
    parameter int LVL_W    = 2;
    parameter int SHIFT_W  = 5;

    localparam int PPN_W   = PTE_W - 1 - PPN_LSB;
    localparam int VPN_W   = VA_W - PG_SHIFT;
    localparam int TZ_W    = $clog2(PPN_W + 1);
    localparam int MARK_B  = PTE_W - 1;

    typedef enum logic [1:0] {
        RES_LEAF  = 2'd0,
        RES_NEXT  = 2'd1,
        RES_FAULT = 2'd2
    } res_e;

    typedef struct packed {
        logic [PTE_W-1:0]   pte;
        logic [VA_W-1:0]    va;
        logic [LVL_W-1:0]   level;
        logic [SHIFT_W-1:0] sp_shift;
        logic               napot_en;
    } eval_req_t;

    typedef struct packed {
        res_e            code;
        logic [PA_W-1:0] pa;
        logic [PA_W-1:0] next_base;
    } eval_rsp_t;

    // Index of lowest set bit; PPN_W when the value is zero.
    function automatic logic [TZ_W-1:0] low_zero_run(input logic [PPN_W-1:0] v);
        logic [TZ_W-1:0] r;
        r = TZ_W'(PPN_W);
        for (int i = PPN_W - 1; i >= 0; i--) begin
            if (v[i]) r = TZ_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pte_classify.sv
module pte_classify
    import pte_eval_pkg::*;
#(
    parameter int NAPOT_K    = 4,
    parameter int LAST_LEVEL = 2
) (
    input  eval_req_t        req,
    output res_e             code,
    output logic             napot_leaf,
    output logic [PPN_W-1:0] ppn
);

    logic       mark, vbit, ubit, abit, dbit;
    logic [2:0] rwx;
    logic [TZ_W-1:0] tz;
    logic       unused_bits;

    assign mark = req.pte[MARK_B];
    assign vbit = req.pte[0];
    assign rwx  = req.pte[3:1];
    assign ubit = req.pte[4];
    assign abit = req.pte[6];
    assign dbit = req.pte[7];
    assign unused_bits = ^{req.pte[9:8], req.pte[5]};

    // Marker cleared before the page number is taken
    assign ppn = req.pte[MARK_B-1:PPN_LSB];
    assign tz  = low_zero_run(ppn);

    always_comb begin
        code       = RES_FAULT;
        napot_leaf = 1'b0;
        if (!req.napot_en && mark) begin
            code = RES_FAULT;
        end else if (!vbit) begin
            code = RES_FAULT;
        end else if (rwx == 3'b000) begin
            code = (dbit | abit | ubit | mark) ? RES_FAULT : RES_NEXT;
        end else if (mark) begin
            // zero page number checked first: its run length is not meaningful
            if (ppn == '0) begin
                code = RES_FAULT;
            end else if (req.level != LVL_W'(LAST_LEVEL)) begin
                code = RES_FAULT;
            end else if ((int'(tz) + 1) != NAPOT_K) begin
                code = RES_FAULT;
            end else begin
                code       = RES_LEAF;
                napot_leaf = 1'b1;
            end
        end else begin
            code = RES_LEAF;
        end
    end

endmodule

// File: rtl/pte_addr_build.sv
module pte_addr_build
    import pte_eval_pkg::*;
#(
    parameter int NAPOT_K = 4
) (
    input  logic [PPN_W-1:0]    ppn,
    input  logic [VA_W-1:0]     va,
    input  logic [SHIFT_W-1:0]  sp_shift,
    input  logic                napot_leaf,
    output logic [PA_W-1:0]     leaf_pa,
    output logic [PA_W-1:0]     table_base
);

    localparam int PG_KEEP = PA_W - PG_SHIFT;

    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] pg;
    logic             unused_hi;

    assign vpn = va[VA_W-1:PG_SHIFT];

    for (genvar i = 0; i < PPN_W; i++) begin : g_pg_bit
        if (i < VPN_W) begin : g_mix
            logic in_region, in_super;
            assign in_region = napot_leaf && (i < NAPOT_K);
            assign in_super  = int'(sp_shift) > i;
            assign pg[i] = (ppn[i] & ~in_region) | (vpn[i] & (in_region | in_super));
        end else begin : g_keep
            assign pg[i] = ppn[i];
        end
    end

    assign leaf_pa    = {pg[PG_KEEP-1:0], va[PG_SHIFT-1:0]};
    assign table_base = {ppn[PG_KEEP-1:0], {PG_SHIFT{1'b0}}};
    assign unused_hi  = ^{pg[PPN_W-1:PG_KEEP], ppn[PPN_W-1:PG_KEEP]};

endmodule

// File: rtl/pte_rsp_stage.sv
module pte_rsp_stage
    import pte_eval_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output logic      in_ready,
    input  eval_rsp_t in_rsp,
    output logic      out_valid,
    input  logic      out_ready,
    output eval_rsp_t out_rsp
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rsp   <= '{code: RES_FAULT, pa: '0, next_base: '0};
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_rsp   <= in_rsp;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pte_eval.sv
module pte_eval
    import pte_eval_pkg::*;
#(
    parameter int NAPOT_K    = 4,
    parameter int LAST_LEVEL = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PTE_W-1:0]   req_pte,
    input  logic [VA_W-1:0]    req_va,
    input  logic [LVL_W-1:0]   req_level,
    input  logic [SHIFT_W-1:0] req_sp_shift,
    input  logic               napot_en,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [1:0]         rsp_code,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [PA_W-1:0]    rsp_next_base
);

    eval_req_t        req;
    res_e             cls_code;
    logic             napot_leaf;
    logic [PPN_W-1:0] ppn;
    logic [PA_W-1:0]  leaf_pa, table_base;
    eval_rsp_t        nxt, held;

    assign req = '{pte: req_pte, va: req_va, level: req_level,
                   sp_shift: req_sp_shift, napot_en: napot_en};

    pte_classify #(.NAPOT_K(NAPOT_K), .LAST_LEVEL(LAST_LEVEL)) u_cls (
        .req        (req),
        .code       (cls_code),
        .napot_leaf (napot_leaf),
        .ppn        (ppn)
    );

    pte_addr_build #(.NAPOT_K(NAPOT_K)) u_addr (
        .ppn        (ppn),
        .va         (req_va),
        .sp_shift   (req_sp_shift),
        .napot_leaf (napot_leaf),
        .leaf_pa    (leaf_pa),
        .table_base (table_base)
    );

    always_comb begin
        nxt.code      = cls_code;
        nxt.pa        = (cls_code == RES_LEAF) ? leaf_pa : '0;
        nxt.next_base = (cls_code == RES_NEXT) ? table_base : '0;
    end

    pte_rsp_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_rsp    (nxt),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_rsp   (held)
    );

    assign rsp_code      = held.code;
    assign rsp_pa        = held.pa;
    assign rsp_next_base = held.next_base;

endmodule

// File: rtl/pte_eval_chk.sv
module pte_eval_chk #(
    parameter int LAST_LEVEL = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_pte,
    input logic [1:0]  req_level,
    input logic        napot_en,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [1:0]  rsp_code,
    input logic [55:0] rsp_pa,
    input logic [55:0] rsp_next_base
);

    logic take;
    assign take = req_valid && req_ready;

    // R11
    reset_idle_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R10
    accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> rsp_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)
            && $stable(rsp_pa) && $stable(rsp_next_base)));

    // R1
    off_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !napot_en && req_pte[63]) |=> rsp_code == 2'd2);

    // R2
    invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !req_pte[0]) |=> rsp_code == 2'd2);

    // R4
    ptr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_pte[0] && req_pte[3:1] == 3'b000
         && (req_pte[7] || req_pte[6] || req_pte[4] || req_pte[63])) |=> rsp_code == 2'd2);

    // R5
    level_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_pte[63] && req_pte[0] && req_pte[3:1] != 3'b000
         && req_level != 2'(LAST_LEVEL)) |=> rsp_code == 2'd2);

    // R9
    pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |-> rsp_pa == '0);

    // R9
    base_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd1) |-> rsp_next_base == '0);

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_code != 2'd3);

endmodule

bind pte_eval pte_eval_chk #(.LAST_LEVEL(LAST_LEVEL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_pte       (req_pte),
    .req_level     (req_level),
    .napot_en      (napot_en),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_code      (rsp_code),
    .rsp_pa        (rsp_pa),
    .rsp_next_base (rsp_next_base)
);

// File: tb/pte_eval_tb.sv
module pte_eval_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_pte = '0;
    logic [38:0] req_va = '0;
    logic [1:0]  req_level = '0;
    logic [4:0]  req_sp_shift = '0;
    logic        napot_en = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_code;
    logic [55:0] rsp_pa;
    logic [55:0] rsp_next_base;

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R11";

    always #(CLK_P/2) clk = ~clk;

    pte_eval u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pte(req_pte), .req_va(req_va), .req_level(req_level),
        .req_sp_shift(req_sp_shift), .napot_en(napot_en),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
        .rsp_pa(rsp_pa), .rsp_next_base(rsp_next_base)
    );

    // Behavioural reference of the evaluation rules
    function automatic void ref_eval(input logic [63:0] pte, input logic [38:0] va,
                                     input int lvl, input int sh, input bit en,
                                     output logic [1:0] code, output logic [55:0] pa,
                                     output logic [55:0] nb);
        logic [63:0] ppn, vpn, km, sm, pg;
        logic [79:0] full;
        int k;
        ppn = {1'b0, pte[62:0]} >> 10;
        code = 2'd2; pa = '0; nb = '0;
        if (!en && pte[63]) return;
        if (!pte[0]) return;
        if (pte[3:1] == 3'b000) begin
            if (pte[7] || pte[6] || pte[4] || pte[63]) return;
            code = 2'd1;
            full = {16'd0, ppn} << 12;
            nb = full[55:0];
            return;
        end
        k = 0;
        if (pte[63]) begin
            if (ppn == 0 || lvl != 2) return;
            while (ppn[k] == 1'b0) k++;
            k = k + 1;
            if (k != 4) return;
        end
        vpn  = {25'd0, va[38:12]};
        km   = (64'd1 << k) - 1;
        sm   = (64'd1 << sh) - 1;
        pg   = (ppn & ~km) | (vpn & km) | (vpn & sm);
        full = ({16'd0, pg} << 12) | {68'd0, va[11:0]};
        pa   = full[55:0];
        code = 2'd0;
    endfunction

    // Cycle model of the output register
    logic        exp_valid = 1'b0;
    logic [1:0]  exp_code = 2'd2;
    logic [55:0] exp_pa = '0, exp_nb = '0;
    string       exp_tag = "R11";
    logic        mdl_ready;
    assign mdl_ready = !exp_valid || rsp_ready;

    always @(posedge clk) begin
        logic [1:0]  c;
        logic [55:0] p, b;
        if (rst) begin
            exp_valid = 1'b0;
        end else if (req_valid && mdl_ready) begin
            ref_eval(req_pte, req_va, int'(req_level), int'(req_sp_shift), napot_en, c, p, b);
            exp_valid = 1'b1; exp_code = c; exp_pa = p; exp_nb = b; exp_tag = cur_tag;
        end else if (rsp_ready) begin
            exp_valid = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        #1;
        check(rsp_valid === exp_valid, exp_valid ? exp_tag : "R11/R10", "rsp_valid",
              64'(rsp_valid), 64'(exp_valid));
        check(req_ready === mdl_ready, "R10", "req_ready", 64'(req_ready), 64'(mdl_ready));
        if (exp_valid) begin
            check(rsp_code === exp_code, exp_tag, "code", 64'(rsp_code), 64'(exp_code));
            check(rsp_pa === exp_pa, exp_tag, "pa", 64'(rsp_pa), 64'(exp_pa));
            check(rsp_next_base === exp_nb, exp_tag, "next_base",
                  64'(rsp_next_base), 64'(exp_nb));
        end
    end

    task automatic send(input logic [63:0] pte, input logic [38:0] va, input int lvl,
                        input int sh, input bit en, input string tag);
        @(negedge clk);
        req_pte = pte; req_va = va; req_level = 2'(lvl); req_sp_shift = 5'(sh);
        napot_en = en; cur_tag = tag; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [63:0] mk(input logic n, input logic [52:0] ppn, input logic [9:0] flags);
        return {n, ppn, flags};
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: marker with the switch off, also with valid clear
        send(mk(1'b1, 53'h12348, 10'h0CF), 39'h12_3456_7ABC, 2, 0, 1'b0, "R1");
        send(mk(1'b1, 53'h12348, 10'h0CE), 39'h12_3456_7ABC, 2, 0, 1'b0, "R1");
        send(mk(1'b1, 53'h00400, 10'h001), 39'h0, 1, 0, 1'b0, "R1");
        // R2: valid clear
        send(mk(1'b0, 53'h5555, 10'h0CE), 39'h7F_0000_1234, 2, 0, 1'b1, "R2");
        // R3: pointers
        send(mk(1'b0, 53'hABCDE, 10'h001), 39'h1, 0, 18, 1'b1, "R3");
        send(mk(1'b0, 53'h1F_FFFF_FFFF_FFFF, 10'h301), 39'h2, 1, 9, 1'b0, "R3");
        // R4: pointer with U, A, D, marker
        send(mk(1'b0, 53'h100, 10'h011), 39'h0, 0, 18, 1'b1, "R4");
        send(mk(1'b0, 53'h100, 10'h041), 39'h0, 0, 18, 1'b1, "R4");
        send(mk(1'b0, 53'h100, 10'h081), 39'h0, 1, 9, 1'b1, "R4");
        send(mk(1'b1, 53'h108, 10'h001), 39'h0, 1, 9, 1'b1, "R4");
        // R5: zero page number and wrong level
        send(mk(1'b1, 53'h0, 10'h0CF), 39'h12_3456_7ABC, 2, 0, 1'b1, "R5");
        send(mk(1'b1, 53'h12348, 10'h0CF), 39'h12_3456_7ABC, 1, 9, 1'b1, "R5");
        send(mk(1'b1, 53'h12348, 10'h0CF), 39'h12_3456_7ABC, 0, 18, 1'b1, "R5");
        // R6: k of 1, 2, 3, 5 and a large run
        send(mk(1'b1, 53'h12341, 10'h0CF), 39'h55_5555_5555, 2, 0, 1'b1, "R6");
        send(mk(1'b1, 53'h12342, 10'h0CF), 39'h55_5555_5555, 2, 0, 1'b1, "R6");
        send(mk(1'b1, 53'h12344, 10'h0CF), 39'h55_5555_5555, 2, 0, 1'b1, "R6");
        send(mk(1'b1, 53'h12350, 10'h0CF), 39'h55_5555_5555, 2, 0, 1'b1, "R6");
        send(mk(1'b1, 53'h10_0000_0000_0000, 10'h0CF), 39'h1, 2, 0, 1'b1, "R6");
        // R7: every page in a legal 64 KiB region
        for (int j = 0; j < 16; j++)
            send(mk(1'b1, 53'h12348, 10'h0CB), {23'h2A_BCDE, 4'(j), 12'hF0F}, 2, 0, 1'b1, "R7");
        send(mk(1'b1, 53'hF_FFFF_FFFF_FFF8, 10'h0C3), 39'h7F_FFFF_5123, 2, 0, 1'b1, "R7");
        // R8: plain leaves at each level
        send(mk(1'b0, 53'h3_0000_0000, 10'h0CF), 39'h7A_BCDE_F123, 0, 18, 1'b1, "R8");
        send(mk(1'b0, 53'h5_4320_0000, 10'h0C7), 39'h12_3456_789A, 1, 9, 1'b1, "R8");
        send(mk(1'b0, 53'h1F_FFFF_FFFF_FFFF, 10'h0C9), 39'h55_AAAA_5555, 2, 0, 1'b0, "R8");
        send(mk(1'b0, 53'h12345, 10'h0CB), 39'h40_0000_0FFF, 2, 0, 1'b1, "R8");
        // R9/R10: backpressure with a second request waiting
        idle();
        @(negedge clk); rsp_ready = 1'b0;
        send(mk(1'b0, 53'hABC, 10'h001), 39'h3, 0, 18, 1'b1, "R10");
        fork
            send(mk(1'b1, 53'h77778, 10'h0CF), 39'h00_0003_A000, 2, 0, 1'b1, "R10");
            begin repeat (4) @(negedge clk); rsp_ready = 1'b1; end
        join
        idle();
        repeat (3) @(negedge clk);
        // R11: reset in mid-stream
        send(mk(1'b0, 53'h1, 10'h001), 39'h0, 0, 18, 1'b1, "R11");
        @(negedge clk); req_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule